// File: doc/BRIEF.md
# GEMM Tile Stage Command Sequencer

This block turns one matrix-multiply job, C = A·B, into the ordered list of stage commands that a single processing element needs to carry it out tile by tile. Software-visible configuration arrives with a start request: the three matrix dimensions, the three tile sizes, the element width in bytes, the base addresses of A, B and C, and a flag per input operand that says the whole operand already sits in local memory. The block walks the tiles with the row-tile loop outermost, the column-tile loop next and the reduction loop innermost, and hands each command to the downstream engines over a valid/ready handshake.

Each command carries a kind (read-DMA, fetch into the register file, multiply-accumulate, store from the register file, write-back to external memory), an address, a byte count and an operand tag. The partial-sum accumulator is assumed to stay in the register file for the whole reduction loop, so the store and write-back commands appear only once per output tile. Reads of a pinned operand are dropped, while the fetch into the register file is always issued. A single-cycle done pulse closes the job.

Top module: `gemm_seq_top`

## Requirements
- R1: The number of tiles along each axis is ceil(dimension / tile size), and is 1 when that quotient is 0 (dimension smaller than a tile, or dimension 0).
- R2: Tiles are visited with the M-tile index outermost, the N-tile index in the middle and the K-tile index innermost, each index counting up from 0.
- R3: Inside one tile the commands appear in the order: read A (kind 0, tag 0), read B (kind 0, tag 1), fetch (kind 1, tag 2), multiply-accumulate (kind 2, tag 3), store (kind 3, tag 3), write-back (kind 4, tag 3), with absent commands simply skipped.
- R4: When the A pinned flag was set at start, no read command with tag 0 is issued for any tile.
- R5: When the B pinned flag was set at start, no read command with tag 1 is issued for any tile.
- R6: The fetch and multiply-accumulate commands are issued for every tile whatever the pinned flags.
- R7: Store and write-back are issued only on the last K tile of each (m,n) pair, and on that tile both are issued.
- R8: Byte counts: read A is tile_m·tile_k·bpe, read B is tile_k·tile_n·bpe, fetch is (tile_m·tile_k + tile_k·tile_n)·bpe, and multiply-accumulate, store and write-back are tile_m·tile_n·bpe.
- R9: Addresses are row-major: A tile at A_base + (m·tile_m·K + k·tile_k)·bpe (read A and fetch), B tile at B_base + (k·tile_k·N + n·tile_n)·bpe, C tile at C_base + (m·tile_m·N + n·tile_n)·bpe (multiply-accumulate, store, write-back).
- R10: While valid is high and ready is low, valid stays high and the kind, address, byte count and tag do not change.
- R11: done pulses high for exactly one cycle, the cycle right after the last command is accepted; busy is low in that cycle and valid is low.
- R12: A start request while busy is ignored; the job in progress continues with the configuration captured at its own start.
- R13: A tile size input of 0 selects the default tile size for that axis: 32 for M, 64 for K, 32 for N.
- R14: After reset, valid, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, accepted only while idle |
| dim_m_i | input | DIM_W | Rows of A and C |
| dim_k_i | input | DIM_W | Reduction length |
| dim_n_i | input | DIM_W | Columns of B and C |
| tile_m_i | input | DIM_W | Tile rows, 0 selects default |
| tile_k_i | input | DIM_W | Tile reduction depth, 0 selects default |
| tile_n_i | input | DIM_W | Tile columns, 0 selects default |
| elem_bytes_i | input | BPE_W | Bytes per element |
| a_base_i | input | ADDR_W | Base address of A |
| b_base_i | input | ADDR_W | Base address of B |
| c_base_i | input | ADDR_W | Base address of C |
| a_pinned_i | input | 1 | A already resident in local memory |
| b_pinned_i | input | 1 | B already resident in local memory |
| busy_o | output | 1 | Job in progress |
| cmd_valid_o | output | 1 | Command available |
| cmd_ready_i | input | 1 | Downstream accepts the command |
| cmd_kind_o | output | 3 | Command kind (0 read, 1 fetch, 2 MAC, 3 store, 4 write-back) |
| cmd_addr_o | output | ADDR_W | Source or destination address |
| cmd_bytes_o | output | ADDR_W | Byte count |
| cmd_tag_o | output | 2 | Operand tag (0 A, 1 B, 2 A and B, 3 C) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in one cycle: a new start request and an ongoing command handshake, including a stalled one. The bench raises start together with a changed dimension and base address exactly while the third command of every job is presented, then checks that every later command still follows the original configuration and that the job ends once. The other overlap, the final write-back acceptance and the job end, is judged by sampling done, busy and valid on the very next cycle and again one cycle later.

// File: rtl/gemm_seq_pkg.sv
// Shared types for the GEMM tile command sequencer.
// Assumes: command kind and tag codes are decoded by downstream engines,
// so their numeric values are fixed.
package gemm_seq_pkg;

    // Command kind codes seen on cmd_kind_o
    typedef enum logic [2:0] {
        KIND_RD    = 3'd0,
        KIND_FETCH = 3'd1,
        KIND_MAC   = 3'd2,
        KIND_STORE = 3'd3,
        KIND_WB    = 3'd4
    } cmd_kind_e;

    // Operand tag codes seen on cmd_tag_o
    typedef enum logic [1:0] {
        TAG_A  = 2'd0,
        TAG_B  = 2'd1,
        TAG_AB = 2'd2,
        TAG_C  = 2'd3
    } cmd_tag_e;

    // Position inside one tile's command list
    typedef enum logic [2:0] {
        STEP_RDA   = 3'd0,
        STEP_RDB   = 3'd1,
        STEP_FETCH = 3'd2,
        STEP_MAC   = 3'd3,
        STEP_STORE = 3'd4,
        STEP_WB    = 3'd5
    } step_e;

    // Job-level control state
    typedef enum logic [1:0] {
        FSM_IDLE  = 2'd0,
        FSM_SETUP = 2'd1,
        FSM_RUN   = 2'd2
    } fsm_e;

endpackage

// File: rtl/gemm_tile_counts.sv
// Per-axis tile count: ceil(dim / tile), never below 1.
// Assumes: purely combinational; caller registers the result.
// A zero tile size is treated as 1 so the divider never sees zero.
module gemm_tile_counts #(
    parameter int DIM_W = 16,
    parameter int AXES  = 3
) (
    input  logic [AXES-1:0][DIM_W-1:0] dims_i,
    input  logic [AXES-1:0][DIM_W-1:0] tiles_i,
    output logic [AXES-1:0][DIM_W-1:0] cnts_o
);
    localparam int SUM_W = DIM_W + 1;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        logic [SUM_W-1:0] divisor;
        logic [SUM_W-1:0] rounded;
        logic [SUM_W-1:0] quotient;

        // Rounded-up division with a floor of one tile
        always_comb begin
            divisor  = (tiles_i[a] == '0) ? SUM_W'(1) : {1'b0, tiles_i[a]};
            rounded  = {1'b0, dims_i[a]} + divisor - SUM_W'(1);
            quotient = rounded / divisor;
            cnts_o[a] = (quotient == '0) ? DIM_W'(1) : quotient[DIM_W-1:0];
        end
    end

endmodule

// File: rtl/gemm_tile_walker.sv
// Nested tile index counters. Axis 0 is innermost (K), the highest
// axis is outermost (M). One advance step bumps axis 0 and ripples a
// carry into the next axis whenever the lower axes all sit on their
// last index.
// Assumes: cnts_i is stable while advancing and every count is >= 1.
module gemm_tile_walker #(
    parameter int DIM_W = 16,
    parameter int AXES  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_i,
    input  logic                       adv_i,
    input  logic [AXES-1:0][DIM_W-1:0] cnts_i,
    output logic [AXES-1:0][DIM_W-1:0] idx_o,
    output logic [AXES-1:0]            last_o,
    output logic                       all_last_o
);
    logic [AXES-1:0] carry;

    assign carry[0]   = adv_i;
    assign all_last_o = &last_o;

    for (genvar a = 0; a < AXES; a++) begin : g_ctr
        assign last_o[a] = (idx_o[a] == cnts_i[a] - DIM_W'(1));

        if (a < AXES - 1) begin : g_carry
            assign carry[a+1] = carry[a] & last_o[a];
        end

        // Index counter for one axis, wraps to 0 after its last tile
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                idx_o[a] <= '0;
            end else if (carry[a]) begin
                idx_o[a] <= last_o[a] ? '0 : idx_o[a] + DIM_W'(1);
            end
        end

        // R1
        idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            idx_o[a] < cnts_i[a]);
    end

endmodule

// File: rtl/gemm_cmd_former.sv
// Builds the command fields for the current step of the current tile:
// kind, operand tag, row-major tile address and byte count.
// Assumes: purely combinational; all products fit in ADDR_W bits.
module gemm_cmd_former
    import gemm_seq_pkg::*;
#(
    parameter int DIM_W  = 16,
    parameter int ADDR_W = 32,
    parameter int BPE_W  = 4
) (
    input  step_e             step_i,
    input  logic [DIM_W-1:0]  m_idx_i,
    input  logic [DIM_W-1:0]  n_idx_i,
    input  logic [DIM_W-1:0]  k_idx_i,
    input  logic [DIM_W-1:0]  dim_k_i,
    input  logic [DIM_W-1:0]  dim_n_i,
    input  logic [DIM_W-1:0]  tile_m_i,
    input  logic [DIM_W-1:0]  tile_k_i,
    input  logic [DIM_W-1:0]  tile_n_i,
    input  logic [BPE_W-1:0]  bpe_i,
    input  logic [ADDR_W-1:0] a_base_i,
    input  logic [ADDR_W-1:0] b_base_i,
    input  logic [ADDR_W-1:0] c_base_i,
    output logic [2:0]        kind_o,
    output logic [1:0]        tag_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] bytes_o
);
    logic [ADDR_W-1:0] mi, ni, ki, dk, dn, tm, tk, tn, be;
    logic [ADDR_W-1:0] a_addr, b_addr, c_addr;
    logic [ADDR_W-1:0] a_bytes, b_bytes, c_bytes;

    // Widen every operand to address width before multiplying
    always_comb begin
        mi = ADDR_W'(m_idx_i);
        ni = ADDR_W'(n_idx_i);
        ki = ADDR_W'(k_idx_i);
        dk = ADDR_W'(dim_k_i);
        dn = ADDR_W'(dim_n_i);
        tm = ADDR_W'(tile_m_i);
        tk = ADDR_W'(tile_k_i);
        tn = ADDR_W'(tile_n_i);
        be = ADDR_W'(bpe_i);
    end

    // Row-major tile origins and full-tile byte sizes
    always_comb begin
        a_addr  = a_base_i + (mi * tm * dk + ki * tk) * be;
        b_addr  = b_base_i + (ki * tk * dn + ni * tn) * be;
        c_addr  = c_base_i + (mi * tm * dn + ni * tn) * be;
        a_bytes = tm * tk * be;
        b_bytes = tk * tn * be;
        c_bytes = tm * tn * be;
    end

    // Select the field set belonging to the current step
    always_comb begin
        unique case (step_i)
            STEP_RDA: begin
                kind_o = KIND_RD;    tag_o = TAG_A;
                addr_o = a_addr;     bytes_o = a_bytes;
            end
            STEP_RDB: begin
                kind_o = KIND_RD;    tag_o = TAG_B;
                addr_o = b_addr;     bytes_o = b_bytes;
            end
            STEP_FETCH: begin
                kind_o = KIND_FETCH; tag_o = TAG_AB;
                addr_o = a_addr;     bytes_o = a_bytes + b_bytes;
            end
            STEP_MAC: begin
                kind_o = KIND_MAC;   tag_o = TAG_C;
                addr_o = c_addr;     bytes_o = c_bytes;
            end
            STEP_STORE: begin
                kind_o = KIND_STORE; tag_o = TAG_C;
                addr_o = c_addr;     bytes_o = c_bytes;
            end
            default: begin
                kind_o = KIND_WB;    tag_o = TAG_C;
                addr_o = c_addr;     bytes_o = c_bytes;
            end
        endcase
    end

endmodule

// File: rtl/gemm_seq_top.sv
// GEMM tile stage command sequencer. Captures a job on start, sizes the
// tile grid, then walks M, N, K tiles (K innermost) issuing one command
// per handshake. Pinned operands skip their read; store and write-back
// close only the last K tile of each output tile.
// Assumes: config inputs are only sampled on an accepted start; the
// command fields are a function of registered state, so they hold
// while a command waits for ready.
module gemm_seq_top
    import gemm_seq_pkg::*;
#(
    parameter int DIM_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int BPE_W      = 4,
    parameter int DEF_TILE_M = 32,
    parameter int DEF_TILE_K = 64,
    parameter int DEF_TILE_N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIM_W-1:0]  dim_m_i,
    input  logic [DIM_W-1:0]  dim_k_i,
    input  logic [DIM_W-1:0]  dim_n_i,
    input  logic [DIM_W-1:0]  tile_m_i,
    input  logic [DIM_W-1:0]  tile_k_i,
    input  logic [DIM_W-1:0]  tile_n_i,
    input  logic [BPE_W-1:0]  elem_bytes_i,
    input  logic [ADDR_W-1:0] a_base_i,
    input  logic [ADDR_W-1:0] b_base_i,
    input  logic [ADDR_W-1:0] c_base_i,
    input  logic              a_pinned_i,
    input  logic              b_pinned_i,
    output logic              busy_o,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [2:0]        cmd_kind_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [ADDR_W-1:0] cmd_bytes_o,
    output logic [1:0]        cmd_tag_o,
    output logic              done_o
);
    localparam int AXES = 3;
    localparam int AX_K = 0;
    localparam int AX_N = 1;
    localparam int AX_M = 2;

    fsm_e                      state;
    step_e                     step, step_first, step_next;
    logic [DIM_W-1:0]          dim_m_q, dim_k_q, dim_n_q;
    logic [DIM_W-1:0]          tile_m_q, tile_k_q, tile_n_q;
    logic [BPE_W-1:0]          bpe_q;
    logic [ADDR_W-1:0]         a_base_q, b_base_q, c_base_q;
    logic                      a_pin_q, b_pin_q;
    logic [AXES-1:0][DIM_W-1:0] dims_w, tiles_w, cnts_w, cnts_q, idx_w;
    logic [AXES-1:0]           last_w;
    logic                      all_last_w;
    logic                      accept, fire, tile_end, job_end;
    logic                      done_q;

    assign accept      = (state == FSM_IDLE) && start_i;
    assign cmd_valid_o = (state == FSM_RUN);
    assign fire        = cmd_valid_o && cmd_ready_i;
    assign busy_o      = (state != FSM_IDLE);
    assign done_o      = done_q;

    // Capture the job configuration on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dim_m_q  <= DIM_W'(1);
            dim_k_q  <= DIM_W'(1);
            dim_n_q  <= DIM_W'(1);
            tile_m_q <= DIM_W'(DEF_TILE_M);
            tile_k_q <= DIM_W'(DEF_TILE_K);
            tile_n_q <= DIM_W'(DEF_TILE_N);
            bpe_q    <= BPE_W'(1);
            a_base_q <= '0;
            b_base_q <= '0;
            c_base_q <= '0;
            a_pin_q  <= 1'b0;
            b_pin_q  <= 1'b0;
        end else if (accept) begin
            dim_m_q  <= dim_m_i;
            dim_k_q  <= dim_k_i;
            dim_n_q  <= dim_n_i;
            tile_m_q <= (tile_m_i == '0) ? DIM_W'(DEF_TILE_M) : tile_m_i;
            tile_k_q <= (tile_k_i == '0) ? DIM_W'(DEF_TILE_K) : tile_k_i;
            tile_n_q <= (tile_n_i == '0) ? DIM_W'(DEF_TILE_N) : tile_n_i;
            bpe_q    <= elem_bytes_i;
            a_base_q <= a_base_i;
            b_base_q <= b_base_i;
            c_base_q <= c_base_i;
            a_pin_q  <= a_pinned_i;
            b_pin_q  <= b_pinned_i;
        end
    end

    // Pack per-axis configuration, axis 0 innermost
    always_comb begin
        dims_w[AX_K]  = dim_k_q;
        dims_w[AX_N]  = dim_n_q;
        dims_w[AX_M]  = dim_m_q;
        tiles_w[AX_K] = tile_k_q;
        tiles_w[AX_N] = tile_n_q;
        tiles_w[AX_M] = tile_m_q;
    end

    gemm_tile_counts #(.DIM_W(DIM_W), .AXES(AXES)) u_counts (
        .dims_i  (dims_w),
        .tiles_i (tiles_w),
        .cnts_o  (cnts_w)
    );

    // Register tile counts during the setup cycle to cut the divider path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < AXES; a++) cnts_q[a] <= DIM_W'(1);
        end else if (state == FSM_SETUP) begin
            cnts_q <= cnts_w;
        end
    end

    gemm_tile_walker #(.DIM_W(DIM_W), .AXES(AXES)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (state == FSM_SETUP),
        .adv_i      (tile_end && !all_last_w),
        .cnts_i     (cnts_q),
        .idx_o      (idx_w),
        .last_o     (last_w),
        .all_last_o (all_last_w)
    );

    // First step of a tile and successor of the current step
    always_comb begin
        if (!a_pin_q)      step_first = STEP_RDA;
        else if (!b_pin_q) step_first = STEP_RDB;
        else               step_first = STEP_FETCH;

        unique case (step)
            STEP_RDA:   step_next = b_pin_q ? STEP_FETCH : STEP_RDB;
            STEP_RDB:   step_next = STEP_FETCH;
            STEP_FETCH: step_next = STEP_MAC;
            STEP_MAC:   step_next = STEP_STORE;
            STEP_STORE: step_next = STEP_WB;
            default:    step_next = STEP_WB;
        endcase

        tile_end = fire && (((step == STEP_MAC) && !last_w[AX_K]) ||
                            (step == STEP_WB));
        job_end  = tile_end && all_last_w;
    end

    // Job-level control: idle, one setup cycle, then run until the last command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FSM_IDLE;
        end else begin
            unique case (state)
                FSM_IDLE:  if (start_i) state <= FSM_SETUP;
                FSM_SETUP: state <= FSM_RUN;
                FSM_RUN:   if (job_end) state <= FSM_IDLE;
                default:   state <= FSM_IDLE;
            endcase
        end
    end

    // Step pointer inside the current tile
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= STEP_RDA;
        end else if (state == FSM_SETUP) begin
            step <= step_first;
        end else if (fire) begin
            step <= tile_end ? step_first : step_next;
        end
    end

    // Completion pulse one cycle after the final acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= job_end;
    end

    gemm_cmd_former #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .BPE_W(BPE_W)) u_former (
        .step_i   (step),
        .m_idx_i  (idx_w[AX_M]),
        .n_idx_i  (idx_w[AX_N]),
        .k_idx_i  (idx_w[AX_K]),
        .dim_k_i  (dim_k_q),
        .dim_n_i  (dim_n_q),
        .tile_m_i (tile_m_q),
        .tile_k_i (tile_k_q),
        .tile_n_i (tile_n_q),
        .bpe_i    (bpe_q),
        .a_base_i (a_base_q),
        .b_base_i (b_base_q),
        .c_base_i (c_base_q),
        .kind_o   (cmd_kind_o),
        .tag_o    (cmd_tag_o),
        .addr_o   (cmd_addr_o),
        .bytes_o  (cmd_bytes_o)
    );

    // R10
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_kind_o) &&
        $stable(cmd_addr_o) && $stable(cmd_bytes_o) && $stable(cmd_tag_o));

    // R11
    done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(cmd_valid_o && cmd_ready_i) && !busy_o);

    // R4
    no_read_a_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && a_pin_q |-> !(cmd_kind_o == 3'd0 && cmd_tag_o == 2'd0));

    // R5
    no_read_b_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && b_pin_q |-> !(cmd_kind_o == 3'd0 && cmd_tag_o == 2'd1));

    // R7
    store_last_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && (cmd_kind_o == 3'd3 || cmd_kind_o == 3'd4) |-> last_w[AX_K]);

    // R12
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> $stable(dim_m_q) && $stable(dim_k_q) &&
        $stable(dim_n_q) && $stable(a_base_q) && $stable(a_pin_q));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/gemm_seq_top_tb.sv
module gemm_seq_top_tb;
    localparam int DIM_W  = 16;
    localparam int ADDR_W = 32;
    localparam int BPE_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [DIM_W-1:0]  dim_m_i = '0, dim_k_i = '0, dim_n_i = '0;
    logic [DIM_W-1:0]  tile_m_i = '0, tile_k_i = '0, tile_n_i = '0;
    logic [BPE_W-1:0]  elem_bytes_i = '0;
    logic [ADDR_W-1:0] a_base_i = '0, b_base_i = '0, c_base_i = '0;
    logic              a_pinned_i = 1'b0, b_pinned_i = 1'b0;
    logic              busy_o, cmd_valid_o, done_o;
    logic              cmd_ready_i = 1'b0;
    logic [2:0]        cmd_kind_o;
    logic [ADDR_W-1:0] cmd_addr_o, cmd_bytes_o;
    logic [1:0]        cmd_tag_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] lfsr = 8'h5b;
    int  cmd_idx;
    bit  inj_on = 1'b0;
    int  sv_m, sv_k, sv_n;
    logic [ADDR_W-1:0] sv_a;

    always #4 clk = ~clk;

    gemm_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dim_m_i(dim_m_i), .dim_k_i(dim_k_i), .dim_n_i(dim_n_i),
        .tile_m_i(tile_m_i), .tile_k_i(tile_k_i), .tile_n_i(tile_n_i),
        .elem_bytes_i(elem_bytes_i),
        .a_base_i(a_base_i), .b_base_i(b_base_i), .c_base_i(c_base_i),
        .a_pinned_i(a_pinned_i), .b_pinned_i(b_pinned_i),
        .busy_o(busy_o), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
        .cmd_kind_o(cmd_kind_o), .cmd_addr_o(cmd_addr_o),
        .cmd_bytes_o(cmd_bytes_o), .cmd_tag_o(cmd_tag_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance to the next falling edge and undo a pending start injection
    task automatic tick();
        @(negedge clk);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (inj_on) begin
            start_i  = 1'b0;
            dim_m_i  = DIM_W'(sv_m);
            dim_k_i  = DIM_W'(sv_k);
            dim_n_i  = DIM_W'(sv_n);
            a_base_i = sv_a;
            inj_on   = 1'b0;
        end
    endtask

    // Wait for one command, compare it, and accept it after random stalls
    task automatic expect_cmd(input int kind, input longint addr, input longint bytes,
                              input int tag, input string req);
        bit acc = 1'b0;
        while (!acc) begin
            tick();
            chk(done_o == 1'b0, "R11", "done during job", done_o, 0);
            if (cmd_valid_o) begin
                chk(cmd_kind_o == 3'(kind), req, "kind", cmd_kind_o, kind);
                chk(cmd_tag_o == 2'(tag), req, "tag", cmd_tag_o, tag);
                chk(cmd_addr_o == ADDR_W'(addr), "R9", "addr", cmd_addr_o, addr);
                chk(cmd_bytes_o == ADDR_W'(bytes), "R8", "bytes", cmd_bytes_o, bytes);
                if (cmd_idx == 2 && !inj_on) begin
                    // R12: start with another config mid-job must be ignored
                    start_i  = 1'b1;
                    dim_m_i  = dim_m_i + DIM_W'(7);
                    dim_k_i  = dim_k_i + DIM_W'(3);
                    dim_n_i  = dim_n_i + DIM_W'(5);
                    a_base_i = a_base_i + 32'h40;
                    inj_on   = 1'b1;
                end
                cmd_ready_i = lfsr[0] | lfsr[1];
                acc = cmd_ready_i;
            end else begin
                cmd_ready_i = lfsr[2];
            end
        end
        cmd_idx++;
    endtask

    task automatic run_case(input int dm, input int dk, input int dn,
                            input int tm_in, input int tk_in, input int tn_in,
                            input int bpe, input bit pa, input bit pb);
        int tm, tk, tn, mt, kt, nt;
        longint ab, bb, cb, aa, ba, ca;
        tm = (tm_in == 0) ? 32 : tm_in;
        tk = (tk_in == 0) ? 64 : tk_in;
        tn = (tn_in == 0) ? 32 : tn_in;
        mt = (dm + tm - 1) / tm; if (mt == 0) mt = 1;
        kt = (dk + tk - 1) / tk; if (kt == 0) kt = 1;
        nt = (dn + tn - 1) / tn; if (nt == 0) nt = 1;
        ab = 64'h1000; bb = 64'h8000; cb = 64'h20000;
        sv_m = dm; sv_k = dk; sv_n = dn; sv_a = ADDR_W'(ab);
        tick();
        dim_m_i = DIM_W'(dm); dim_k_i = DIM_W'(dk); dim_n_i = DIM_W'(dn);
        tile_m_i = DIM_W'(tm_in); tile_k_i = DIM_W'(tk_in); tile_n_i = DIM_W'(tn_in);
        elem_bytes_i = BPE_W'(bpe);
        a_base_i = ADDR_W'(ab); b_base_i = ADDR_W'(bb); c_base_i = ADDR_W'(cb);
        a_pinned_i = pa; b_pinned_i = pb;
        start_i = 1'b1;
        cmd_idx = 0;
        tick();
        start_i = 1'b0;
        // R2: M outer, N middle, K inner; R1: per-axis counts
        for (int m = 0; m < mt; m++)
            for (int n = 0; n < nt; n++)
                for (int k = 0; k < kt; k++) begin
                    aa = ab + longint'((m * tm * dk + k * tk) * bpe);
                    ba = bb + longint'((k * tk * dn + n * tn) * bpe);
                    ca = cb + longint'((m * tm * dn + n * tn) * bpe);
                    if (!pa) expect_cmd(0, aa, tm * tk * bpe, 0, "R4");
                    if (!pb) expect_cmd(0, ba, tk * tn * bpe, 1, "R5");
                    expect_cmd(1, aa, (tm * tk + tk * tn) * bpe, 2, "R6");
                    expect_cmd(2, ca, tm * tn * bpe, 3, "R3");
                    if (k == kt - 1) begin
                        expect_cmd(3, ca, tm * tn * bpe, 3, "R7");
                        expect_cmd(4, ca, tm * tn * bpe, 3, "R7");
                    end
                end
        tick();
        cmd_ready_i = 1'b0;
        chk(done_o == 1'b1, "R11", "done after last accept", done_o, 1);
        chk(busy_o == 1'b0, "R11", "busy at done", busy_o, 0);
        chk(cmd_valid_o == 1'b0, "R11", "valid at done", cmd_valid_o, 0);
        tick();
        chk(done_o == 1'b0, "R11", "done width", done_o, 0);
        chk(cmd_valid_o == 1'b0, "R1", "extra command", cmd_valid_o, 0);
    endtask

    initial begin
        int dms[3] = '{1, 4, 5};
        int dks[3] = '{3, 8, 9};
        int dns[2] = '{2, 3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14: reset state
        chk(cmd_valid_o == 1'b0, "R14", "valid", cmd_valid_o, 0);
        chk(busy_o == 1'b0, "R14", "busy", busy_o, 0);
        chk(done_o == 1'b0, "R14", "done", done_o, 0);
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                for (int h = 0; h < 2; h++)
                    for (int p = 0; p < 4; p++)
                        run_case(dms[i], dks[j], dns[h], 2, 4, 2,
                                 (p == 3) ? 4 : 2, p[0], p[1]);
        // R13: default tile sizes, multi-tile along K and under-tile case
        run_case(32, 128, 32, 0, 0, 0, 2, 1'b0, 1'b0);
        run_case(8, 8, 8, 0, 0, 0, 2, 1'b1, 1'b0);
        run_case(70, 130, 40, 0, 0, 0, 1, 1'b0, 1'b1);
        // R1: zero dimension still yields one tile
        run_case(0, 0, 0, 2, 4, 2, 2, 1'b1, 1'b1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule